// File: doc/BRIEF.md
# Character-Cell Video Overlay

This block paints a rectangular window of text characters over a stream of video pixels. Software sets up the window through a small 16-bit register file: where the top-left corner sits in the frame, how many columns and rows of cells it spans, and how the pixels are blended. It fills a dual-ported cell memory with one word per character. Each word holds an 8-bit character code and an 8-bit colour attribute.

Every incoming pixel carries its own frame coordinates. The block decides whether the pixel falls inside the window. If it does, the block works out which cell the pixel belongs to and its position inside that cell, reads the cell word, and asks an external glyph lookup port for the bitmap row of that character.

A set glyph bit produces the attribute colour. A clear bit produces the background video, which is filtered according to the control register. Pixels outside the window, and all pixels when the overlay is not active, leave unchanged. Sync and valid flags travel through the same pipeline as the colour, so the output stream stays aligned.

Top module: `osd_text_overlay`

## Requirements
- R1: Reads return the addressed register one cycle after the address is presented. Address 0 reads the version as major*100+minor, and address 1 reads the feature word {maximum columns-1 in [13:8], maximum rows-1 in [4:0]}. Writes to addresses 0 and 1 have no effect.
- R2: The control register is at address 2. It holds the filter in [1:0], the mode in [4:3] (0 passthrough, 1 overlay, 2 keep-background overlay, 3 off), the enable in bit 6 and a sync source code in [10:8]. All other bits read 0, and the reset value is 0x0001.
- R3: The size register is at address 3. It holds columns-1 in [13:8] and rows-1 in [4:0]. A written value above 52 (columns) or 25 (rows) is stored as 52 or 25, and the reset value is 0x3419.
- R4: The scale register is at address 4. It stores and reads back all 16 bits and has no effect on the pixels. The X position is at address 5 and the Y position at address 6; each is an 11-bit field in [10:0].
- R5: Output valid, hsync, vsync and colour for an input pixel appear four clock cycles after the edge that samples it.
- R6: When enable is 0, the mode is passthrough or off, or the pixel lies outside the window, the output colour equals the input colour.
- R7: A pixel (x,y) lies inside the window when X <= x < X+12*columns and Y <= y < Y+18*rows.
- R8: The pixel uses cell word index (dy/18)*columns + dx/12, where dx = x-X and dy = y-Y. The cell memory is written through its own port, and a word written on one edge is readable on the next.
- R9: The glyph port presents the cell's upper byte as the code and dy%18 as the row. It samples the 12-bit bitmap in the same cycle, and bit 11 is the leftmost pixel column (dx%12 = 0).
- R10: A set glyph bit outputs the attribute colour expanded from 3-3-2 bits. The output colour word is {red[23:16], green[15:8], blue[7:0]}, and each field is replicated to fill its 8 bits.
- R11: A clear glyph bit in overlay mode outputs the background through the filter: 0 black, 1 unchanged, 2 each component halved, 3 each component set to the integer mean of the three.
- R12: In keep-background mode (mode 2), set glyph bits still draw the attribute colour, and clear bits pass the input colour unfiltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| cell_wr_en | input | 1 | Cell memory write strobe |
| cell_wr_addr | input | 11 | Cell memory write index |
| cell_wr_data | input | 16 | Cell word: code [15:8], attribute [7:0] |
| glyph_code | output | 8 | Character code for the glyph lookup |
| glyph_row | output | 5 | Row within the character cell |
| glyph_bits | input | 12 | Glyph bitmap row, bit 11 leftmost |
| vid_in_valid | input | 1 | Input pixel valid |
| vid_in_hsync | input | 1 | Input horizontal sync |
| vid_in_vsync | input | 1 | Input vertical sync |
| vid_in_x | input | 11 | Pixel column in the frame |
| vid_in_y | input | 11 | Pixel line in the frame |
| vid_in_rgb | input | 24 | Input colour {r,g,b} |
| vid_out_valid | output | 1 | Delayed valid |
| vid_out_hsync | output | 1 | Delayed horizontal sync |
| vid_out_vsync | output | 1 | Delayed vertical sync |
| vid_out_rgb | output | 24 | Output colour {r,g,b} |

## Verification
The bench uses the default parameters: 11-bit coordinates, a 64 by 32 cell memory, a usable limit of 53 by 26 cells, and version 1.07. It programs a 4 by 3 window at (100,50). At that size every window edge, the last cell, and pixels just outside each side are reachable with a handful of vectors. The same vectors run under every filter and mode. A glyph model in the bench lets specific bitmap bits be predicted, so both foreground and background paths are exercised.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
package osd_pkg;

    localparam int CELL_W = 12;
    localparam int CELL_H = 18;
    localparam int PXW    = 4;
    localparam int PYW    = 5;

    localparam logic [2:0] RA_VERSION = 3'd0;
    localparam logic [2:0] RA_FEATURE = 3'd1;
    localparam logic [2:0] RA_CTRL    = 3'd2;
    localparam logic [2:0] RA_SIZE    = 3'd3;
    localparam logic [2:0] RA_SCALE   = 3'd4;
    localparam logic [2:0] RA_XPOS    = 3'd5;
    localparam logic [2:0] RA_YPOS    = 3'd6;

    localparam logic [15:0] CTRL_MASK = 16'h075B;

    typedef enum logic [1:0] {
        FLT_BLACK = 2'd0,
        FLT_ORIG  = 2'd1,
        FLT_DARK  = 2'd2,
        FLT_GRAY  = 2'd3
    } filt_e;

    typedef enum logic [1:0] {
        MD_PASS = 2'd0,
        MD_OSD  = 2'd1,
        MD_KEEP = 2'd2,
        MD_OFF  = 2'd3
    } mode_e;

    typedef struct packed {
        logic [2:0] sync_src;
        logic       enable;
        mode_e      mode;
        filt_e      filter;
    } ctrl_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic hs;
        logic vs;
        rgb_t rgb;
    } vid_t;

    typedef struct packed {
        logic           draw;
        logic           keep_bg;
        filt_e          filt;
        logic [PXW-1:0] px;
        logic [PYW-1:0] py;
    } tag_t;

    function automatic rgb_t attr_to_rgb(input logic [7:0] a);
        rgb_t c;
        c.r = {a[7:5], a[7:5], a[7:6]};
        c.g = {a[4:2], a[4:2], a[4:3]};
        c.b = {a[1:0], a[1:0], a[1:0], a[1:0]};
        return c;
    endfunction

    function automatic rgb_t filter_bg(input rgb_t p, input filt_e f);
        rgb_t       c;
        logic [9:0] sum;
        logic [7:0] avg;
        sum = 10'(p.r) + 10'(p.g) + 10'(p.b);
        avg = 8'(sum / 10'd3);
        case (f)
            FLT_BLACK: c = '0;
            FLT_ORIG:  c = p;
            FLT_DARK:  c = '{r: p.r >> 1, g: p.g >> 1, b: p.b >> 1};
            default:   c = '{r: avg, g: avg, b: avg};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/osd_regs.sv
`timescale 1ns/1ps
module osd_regs
    import osd_pkg::*;
#(
    parameter int CW        = 11,
    parameter int MAX_COLS  = 64,
    parameter int MAX_ROWS  = 32,
    parameter int USE_COLS  = 53,
    parameter int USE_ROWS  = 26,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 7,
    localparam int CB = $clog2(MAX_COLS),
    localparam int RB = $clog2(MAX_ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output ctrl_t         ctrl,
    output logic [CB-1:0] cols_m1,
    output logic [RB-1:0] rows_m1,
    output logic [CW-1:0] xpos,
    output logic [CW-1:0] ypos
);
    localparam logic [15:0] VERSION_WORD = 16'(VER_MAJOR * 100 + VER_MINOR);
    localparam logic [15:0] FEATURE_WORD = 16'(((MAX_COLS - 1) << 8) | (MAX_ROWS - 1));
    localparam logic [CB-1:0] COL_LIM = CB'(USE_COLS - 1);
    localparam logic [RB-1:0] ROW_LIM = RB'(USE_ROWS - 1);

    logic [15:0] scale_q;
    logic [15:0] ctrl_word;
    logic [15:0] size_word;
    logic [15:0] rd_mux;

    assign ctrl_word = {5'b0, ctrl.sync_src, 1'b0, ctrl.enable, 1'b0,
                        ctrl.mode, 1'b0, ctrl.filter};
    assign size_word = 16'({cols_m1, 8'b0}) | 16'(rows_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{sync_src: 3'd0, enable: 1'b0, mode: MD_PASS, filter: FLT_ORIG};
            cols_m1 <= COL_LIM;
            rows_m1 <= ROW_LIM;
            scale_q <= '0;
            xpos    <= '0;
            ypos    <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL: begin
                    ctrl.sync_src <= wdata[10:8];
                    ctrl.enable   <= wdata[6];
                    ctrl.mode     <= mode_e'(wdata[4:3]);
                    ctrl.filter   <= filt_e'(wdata[1:0]);
                end
                RA_SIZE: begin
                    cols_m1 <= (wdata[8 +: CB] > COL_LIM) ? COL_LIM : wdata[8 +: CB];
                    rows_m1 <= (wdata[0 +: RB] > ROW_LIM) ? ROW_LIM : wdata[0 +: RB];
                end
                RA_SCALE: scale_q <= wdata;
                RA_XPOS:  xpos    <= wdata[CW-1:0];
                RA_YPOS:  ypos    <= wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RA_VERSION: rd_mux = VERSION_WORD;
            RA_FEATURE: rd_mux = FEATURE_WORD;
            RA_CTRL:    rd_mux = ctrl_word;
            RA_SIZE:    rd_mux = size_word;
            RA_SCALE:   rd_mux = scale_q;
            RA_XPOS:    rd_mux = 16'(xpos);
            RA_YPOS:    rd_mux = 16'(ypos);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_mux;
    end

    assert_version_ro_R1: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_VERSION) |=> (rdata == VERSION_WORD));

    assert_ctrl_fields_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_CTRL) |=> (ctrl_word == ($past(wdata) & CTRL_MASK)));

    assert_col_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_SIZE && wdata[8 +: CB] > COL_LIM) |=> (cols_m1 == COL_LIM));

    assert_row_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_SIZE && wdata[0 +: RB] > ROW_LIM) |=> (rows_m1 == ROW_LIM));

endmodule

// File: rtl/osd_cell_ram.sv
`timescale 1ns/1ps
module osd_cell_ram #(
    parameter int DW = 16,
    parameter int AW = 11,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

    // R8: a word written on one edge is returned by a read on the next
    assert_rd_after_wr_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && $past(waddr) == raddr && !(we && waddr == raddr))
        |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/osd_pixel_pipe.sv
`timescale 1ns/1ps
module osd_pixel_pipe
    import osd_pkg::*;
#(
    parameter int CW = 11,
    parameter int CB = 6,
    parameter int RB = 5,
    parameter int AW = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ov_enable,
    input  mode_e            ov_mode,
    input  filt_e            ov_filter,
    input  logic [CB-1:0]    cols_m1,
    input  logic [RB-1:0]    rows_m1,
    input  logic [CW-1:0]    xpos,
    input  logic [CW-1:0]    ypos,
    input  logic             vid_in_valid,
    input  logic             vid_in_hsync,
    input  logic             vid_in_vsync,
    input  logic [CW-1:0]    vid_in_x,
    input  logic [CW-1:0]    vid_in_y,
    input  logic [23:0]      vid_in_rgb,
    output logic [AW-1:0]    cell_raddr,
    input  logic [15:0]      cell_rdata,
    output logic [7:0]       glyph_code,
    output logic [PYW-1:0]   glyph_row,
    input  logic [CELL_W-1:0] glyph_bits,
    output logic             vid_out_valid,
    output logic             vid_out_hsync,
    output logic             vid_out_vsync,
    output logic [23:0]      vid_out_rgb
);
    // stage 0: window test and cell address
    logic [CW:0]   dx_full, dy_full;
    logic [CW-1:0] dx, dy, win_w, win_h;
    logic          in_x, in_y, active;
    logic [CB-1:0] col;
    logic [RB-1:0] row;
    tag_t          t0;
    vid_t          v0;
    logic [AW-1:0] a0;

    assign dx_full = {1'b0, vid_in_x} - {1'b0, xpos};
    assign dy_full = {1'b0, vid_in_y} - {1'b0, ypos};
    assign dx      = dx_full[CW-1:0];
    assign dy      = dy_full[CW-1:0];
    assign win_w   = CW'((int'(cols_m1) + 1) * CELL_W);
    assign win_h   = CW'((int'(rows_m1) + 1) * CELL_H);
    assign in_x    = !dx_full[CW] && (dx < win_w);
    assign in_y    = !dy_full[CW] && (dy < win_h);
    assign active  = ov_enable && (ov_mode == MD_OSD || ov_mode == MD_KEEP);
    assign col     = CB'(dx / CW'(CELL_W));
    assign row     = RB'(dy / CW'(CELL_H));

    always_comb begin
        t0.draw    = active && in_x && in_y;
        t0.keep_bg = (ov_mode == MD_KEEP);
        t0.filt    = ov_filter;
        t0.px      = PXW'(dx % CW'(CELL_W));
        t0.py      = PYW'(dy % CW'(CELL_H));
        v0         = '{valid: vid_in_valid, hs: vid_in_hsync, vs: vid_in_vsync,
                       rgb: rgb_t'(vid_in_rgb)};
        a0         = AW'(int'(row) * (int'(cols_m1) + 1) + int'(col));
    end

    // stage registers
    vid_t           v1, v2, v3, vo;
    tag_t           t1, t2;
    logic [AW-1:0]  a1;
    logic           s3_draw, s3_keep, s3_fg;
    filt_e          s3_filt;
    logic [7:0]     s3_attr;
    logic [PXW-1:0] bit_idx;

    assign cell_raddr = a1;
    assign glyph_code = cell_rdata[15:8];
    assign glyph_row  = t2.py;
    assign bit_idx    = PXW'(CELL_W - 1) - t2.px;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= '0; v2 <= '0; v3 <= '0; vo <= '0;
            t1 <= '0; t2 <= '0; a1 <= '0;
            s3_draw <= 1'b0; s3_keep <= 1'b0; s3_fg <= 1'b0;
            s3_filt <= FLT_BLACK; s3_attr <= '0;
        end else begin
            v1 <= v0; t1 <= t0; a1 <= a0;
            v2 <= v1; t2 <= t1;
            v3      <= v2;
            s3_draw <= t2.draw;
            s3_keep <= t2.keep_bg;
            s3_filt <= t2.filt;
            s3_fg   <= glyph_bits[bit_idx];
            s3_attr <= cell_rdata[7:0];
            vo.valid <= v3.valid;
            vo.hs    <= v3.hs;
            vo.vs    <= v3.vs;
            if (!s3_draw)     vo.rgb <= v3.rgb;
            else if (s3_fg)   vo.rgb <= attr_to_rgb(s3_attr);
            else if (s3_keep) vo.rgb <= v3.rgb;
            else              vo.rgb <= filter_bg(v3.rgb, s3_filt);
        end
    end

    assign vid_out_valid = vo.valid;
    assign vid_out_hsync = vo.hs;
    assign vid_out_vsync = vo.vs;
    assign vid_out_rgb   = vo.rgb;

    // cycles since reset, saturating at the pipeline depth
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 3'd4) warm <= warm + 3'd1;
    end

    assert_sync_align_R5: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'd4) |-> (vid_out_valid == $past(vid_in_valid, 4)
                            && vid_out_hsync == $past(vid_in_hsync, 4)
                            && vid_out_vsync == $past(vid_in_vsync, 4)));

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'd4 && !$past(s3_draw)) |-> (vid_out_rgb == $past(vid_in_rgb, 4)));

    assert_glyph_row_R9: assert property (@(posedge clk) disable iff (rst)
        t2.draw |-> (glyph_row < PYW'(CELL_H)));

endmodule

// File: rtl/osd_text_overlay.sv
`timescale 1ns/1ps
module osd_text_overlay
    import osd_pkg::*;
#(
    parameter int CW        = 11,
    parameter int MAX_COLS  = 64,
    parameter int MAX_ROWS  = 32,
    parameter int USE_COLS  = 53,
    parameter int USE_ROWS  = 26,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 7
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  reg_wr_en,
    input  logic [2:0]                            reg_addr,
    input  logic [15:0]                           reg_wdata,
    output logic [15:0]                           reg_rdata,
    input  logic                                  cell_wr_en,
    input  logic [$clog2(MAX_COLS*MAX_ROWS)-1:0]  cell_wr_addr,
    input  logic [15:0]                           cell_wr_data,
    output logic [7:0]                            glyph_code,
    output logic [4:0]                            glyph_row,
    input  logic [11:0]                           glyph_bits,
    input  logic                                  vid_in_valid,
    input  logic                                  vid_in_hsync,
    input  logic                                  vid_in_vsync,
    input  logic [CW-1:0]                         vid_in_x,
    input  logic [CW-1:0]                         vid_in_y,
    input  logic [23:0]                           vid_in_rgb,
    output logic                                  vid_out_valid,
    output logic                                  vid_out_hsync,
    output logic                                  vid_out_vsync,
    output logic [23:0]                           vid_out_rgb
);
    localparam int AW = $clog2(MAX_COLS * MAX_ROWS);
    localparam int CB = $clog2(MAX_COLS);
    localparam int RB = $clog2(MAX_ROWS);

    ctrl_t         ctrl;
    logic [CB-1:0] cols_m1;
    logic [RB-1:0] rows_m1;
    logic [CW-1:0] xpos, ypos;
    logic [AW-1:0] cell_raddr;
    logic [15:0]   cell_rdata;

    osd_regs #(
        .CW(CW), .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS),
        .USE_COLS(USE_COLS), .USE_ROWS(USE_ROWS),
        .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .ctrl(ctrl), .cols_m1(cols_m1), .rows_m1(rows_m1),
        .xpos(xpos), .ypos(ypos)
    );

    osd_cell_ram #(.DW(16), .AW(AW)) u_cells (
        .clk(clk), .rst(rst),
        .we(cell_wr_en), .waddr(cell_wr_addr), .wdata(cell_wr_data),
        .raddr(cell_raddr), .rdata(cell_rdata)
    );

    osd_pixel_pipe #(.CW(CW), .CB(CB), .RB(RB), .AW(AW)) u_pipe (
        .clk(clk), .rst(rst),
        .ov_enable(ctrl.enable), .ov_mode(ctrl.mode), .ov_filter(ctrl.filter),
        .cols_m1(cols_m1), .rows_m1(rows_m1), .xpos(xpos), .ypos(ypos),
        .vid_in_valid(vid_in_valid), .vid_in_hsync(vid_in_hsync),
        .vid_in_vsync(vid_in_vsync), .vid_in_x(vid_in_x), .vid_in_y(vid_in_y),
        .vid_in_rgb(vid_in_rgb),
        .cell_raddr(cell_raddr), .cell_rdata(cell_rdata),
        .glyph_code(glyph_code), .glyph_row(glyph_row), .glyph_bits(glyph_bits),
        .vid_out_valid(vid_out_valid), .vid_out_hsync(vid_out_hsync),
        .vid_out_vsync(vid_out_vsync), .vid_out_rgb(vid_out_rgb)
    );

endmodule

// File: tb/osd_text_overlay_bench.sv
`timescale 1ns/1ps
module osd_text_overlay_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 11;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr_en;
    logic [2:0]    reg_addr;
    logic [15:0]   reg_wdata;
    logic [15:0]   reg_rdata;
    logic          cell_wr_en;
    logic [AW-1:0] cell_wr_addr;
    logic [15:0]   cell_wr_data;
    logic [7:0]    glyph_code;
    logic [4:0]    glyph_row;
    logic [11:0]   glyph_bits;
    logic          vid_in_valid, vid_in_hsync, vid_in_vsync;
    logic [CW-1:0] vid_in_x, vid_in_y;
    logic [23:0]   vid_in_rgb;
    logic          vid_out_valid, vid_out_hsync, vid_out_vsync;
    logic [23:0]   vid_out_rgb;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    osd_text_overlay u_osd_text_overlay (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cell_wr_en(cell_wr_en), .cell_wr_addr(cell_wr_addr), .cell_wr_data(cell_wr_data),
        .glyph_code(glyph_code), .glyph_row(glyph_row), .glyph_bits(glyph_bits),
        .vid_in_valid(vid_in_valid), .vid_in_hsync(vid_in_hsync), .vid_in_vsync(vid_in_vsync),
        .vid_in_x(vid_in_x), .vid_in_y(vid_in_y), .vid_in_rgb(vid_in_rgb),
        .vid_out_valid(vid_out_valid), .vid_out_hsync(vid_out_hsync),
        .vid_out_vsync(vid_out_vsync), .vid_out_rgb(vid_out_rgb)
    );

    // glyph source model
    function automatic logic [11:0] glyph_of(input logic [7:0] c, input logic [4:0] r);
        return {c[5:0], c[7:2]} ^ {7'd0, r};
    endfunction
    always_comb glyph_bits = glyph_of(glyph_code, glyph_row);

    // bench view of programmed state
    logic [15:0] cells [0:63];
    logic [15:0] ctrl_m = 16'h0001;
    int xp = 0, yp = 0, ncols = 4, nrows = 3;

    function automatic logic [23:0] exp_pix(input int x, input int y, input logic [23:0] in);
        int dx, dy, idx, s;
        logic [15:0] w;
        logic [11:0] g;
        logic [7:0]  a;
        if (!ctrl_m[6] || !(ctrl_m[4:3] == 2'd1 || ctrl_m[4:3] == 2'd2)) return in;
        dx = x - xp;
        dy = y - yp;
        if (dx < 0 || dy < 0 || dx >= ncols * 12 || dy >= nrows * 18) return in;
        idx = (dy / 18) * ncols + dx / 12;
        w   = cells[idx];
        g   = glyph_of(w[15:8], 5'(dy % 18));
        if (g[11 - dx % 12]) begin
            a = w[7:0];
            return {a[7:5], a[7:5], a[7:6], a[4:2], a[4:2], a[4:3], {4{a[1:0]}}};
        end
        if (ctrl_m[4:3] == 2'd2) return in;
        case (ctrl_m[1:0])
            2'd0: return 24'h0;
            2'd1: return in;
            2'd2: return {in[23:16] >> 1, in[15:8] >> 1, in[7:0] >> 1};
            default: begin
                s = (int'(in[23:16]) + int'(in[15:8]) + int'(in[7:0])) / 3;
                return {3{8'(s)}};
            end
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        check(32'(reg_rdata), 32'(exp), req);
    endtask

    task automatic wr_cell(input int a, input logic [15:0] d);
        @(negedge clk);
        cell_wr_en = 1'b1; cell_wr_addr = AW'(a); cell_wr_data = d;
        cells[a] = d;
        @(negedge clk);
        cell_wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic [15:0] v);
        wr_reg(3'd2, v);
        ctrl_m = v & 16'h075B;
    endtask

    task automatic pix_check(input int x, input int y, input logic [23:0] rgb, input string req);
        @(negedge clk);
        vid_in_valid = 1'b1; vid_in_x = CW'(x); vid_in_y = CW'(y); vid_in_rgb = rgb;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(32'(vid_out_rgb), 32'(exp_pix(x, y, rgb)), req);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // stimulus vectors {x, y, rgb} around a 4x3 window at (100,50)
    localparam logic [45:0] VEC [0:9] = '{
        {11'd99,  11'd60,  24'h806040},
        {11'd100, 11'd50,  24'h102030},
        {11'd147, 11'd103, 24'hF0E0D0},
        {11'd148, 11'd60,  24'h445566},
        {11'd120, 11'd49,  24'h778899},
        {11'd120, 11'd104, 24'hAABBCC},
        {11'd113, 11'd70,  24'h3C5A7E},
        {11'd125, 11'd88,  24'hFF0080},
        {11'd139, 11'd55,  24'h12EF34},
        {11'd105, 11'd95,  24'h9090F0}
    };
    localparam logic [15:0] CFG [0:7] = '{
        16'h0048, 16'h0049, 16'h004A, 16'h004B,
        16'h0052, 16'h0041, 16'h0059, 16'h0009
    };

    function automatic string cfg_tag(input int i);
        case (i)
            0, 1, 2, 3: return "R11 R7 R10";
            4:          return "R12 R7 R10";
            default:    return "R6";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst = 1'b1;
        reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
        cell_wr_en = 0; cell_wr_addr = 0; cell_wr_data = 0;
        vid_in_valid = 0; vid_in_hsync = 0; vid_in_vsync = 0;
        vid_in_x = 0; vid_in_y = 0; vid_in_rgb = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        rd_check(3'd0, 16'd107, "R1 version");
        rd_check(3'd1, 16'h3F1F, "R1 features");
        rd_check(3'd2, 16'h0001, "R2 reset");
        rd_check(3'd3, 16'h3419, "R3 reset");
        rd_check(3'd5, 16'h0000, "R4 xpos reset");
        check(32'(vid_out_valid), 32'd0, "R5 reset valid");

        // read-only registers ignore writes
        wr_reg(3'd0, 16'h1234);
        rd_check(3'd0, 16'd107, "R1 ignored write");
        wr_reg(3'd1, 16'hFFFF);
        rd_check(3'd1, 16'h3F1F, "R1 ignored write");

        // control fields
        set_ctrl(16'hFFFF);
        rd_check(3'd2, 16'h075B, "R2 mask");

        // size clamping
        wr_reg(3'd3, 16'h3F3F);
        rd_check(3'd3, 16'h3419, "R3 clamp");
        wr_reg(3'd3, 16'h3518);
        rd_check(3'd3, 16'h3418, "R3 col clamp");
        wr_reg(3'd3, 16'h0302);
        rd_check(3'd3, 16'h0302, "R3 plain");

        // position
        wr_reg(3'd5, 16'd100); xp = 100;
        wr_reg(3'd6, 16'd50);  yp = 50;
        rd_check(3'd5, 16'd100, "R4 xpos");
        rd_check(3'd6, 16'd50,  "R4 ypos");

        for (int i = 0; i < 12; i++)
            wr_cell(i, {8'(i * 37 + 5), 8'(i * 29 + 11)});

        // table walk over modes and filters
        for (int c = 0; c < 8; c++) begin
            set_ctrl(CFG[c]);
            for (int v = 0; v < 10; v++)
                pix_check(int'(VEC[v][45:35]), int'(VEC[v][34:24]), VEC[v][23:0], cfg_tag(c));
        end

        // R10: known foreground bit, R11 background beside it
        set_ctrl(16'h0048);
        wr_cell(0, 16'h20E3);
        pix_check(100, 50, 24'h123456, "R10 fg");
        check(32'(vid_out_rgb), 32'hFF00FF, "R10 colour");
        pix_check(101, 50, 24'h123456, "R11 black bg");
        check(32'(vid_out_rgb), 32'h000000, "R11 black");

        // R9: glyph port code and row
        wr_cell(6, 16'h5A33);
        @(negedge clk);
        vid_in_x = CW'(129); vid_in_y = CW'(75); vid_in_rgb = 24'h0F0F0F;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(32'(glyph_code), 32'h5A, "R9 code");
        check(32'(glyph_row), 32'd7, "R9 row");
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(32'(vid_out_rgb), 32'(exp_pix(129, 75, 24'h0F0F0F)), "R9 pixel");

        // R8: rewriting a cell changes only that cell's pixels
        wr_cell(5, 16'hFF1C);
        pix_check(112, 68, 24'h808080, "R8 new word");
        pix_check(112, 50, 24'h808080, "R8 neighbour");

        // R4: scale has no effect
        set_ctrl(16'h004B);
        wr_reg(3'd4, 16'hABCD);
        rd_check(3'd4, 16'hABCD, "R4 scale");
        pix_check(113, 70, 24'h3C5A7E, "R4 scale no effect");

        // R5: sync alignment
        @(negedge clk);
        vid_in_valid = 0; vid_in_hsync = 0; vid_in_vsync = 0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        vid_in_valid = 1; vid_in_hsync = 1; vid_in_vsync = 1;
        @(negedge clk);
        vid_in_valid = 0; vid_in_hsync = 0; vid_in_vsync = 0;
        check(32'(vid_out_valid), 32'd0, "R5 early");
        @(negedge clk);
        @(negedge clk);
        check(32'(vid_out_hsync), 32'd0, "R5 early");
        @(negedge clk);
        check(32'({vid_out_valid, vid_out_hsync, vid_out_vsync}), 32'd7, "R5 aligned");
        @(negedge clk);
        check(32'(vid_out_valid), 32'd0, "R5 after");

        report();
    end

endmodule